// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor bus three parallel ports: two full-width ports (A and B) and a third port (C) that is handled as two independent nibbles. Each of the four groups (A, B, C upper, C lower) can be an input or an output. An output group drives its pins from a latch that holds what was last written. An input group passes the live pin values straight to the bus on a read. There is no handshaking: a write to a port address loads that port's latch on the next clock edge.

A single control address takes two kinds of word, and bit 7 of the word selects the kind. A configuration word sets the direction of the four groups and clears every output latch and both interrupt-enable flops. A bit command sets or clears one port C latch bit and leaves the other bits alone. Two interrupt-enable flops, one per port group, follow bit commands on their assigned port C bits. Interrupt generation itself is not part of this block.

Top module: `pio_port_ctrl`

## Requirements
- R1: After reset, all four groups are inputs, every output-enable bit is 0, all three latches are 0 and both interrupt-enable flops are 0.
- R2: While `cs` and `wr` are high at a clock edge, address 0 loads port A's latch, address 1 port B's latch and address 2 port C's latch from `wrData`. The latch is visible on the matching `*Out` port after that edge, whatever the group's direction.
- R3: A configuration word has bit 7 = 1 and bits 6, 5 and 2 = 0. Bit 4 sets port A's direction, bit 3 sets C upper, bit 1 sets port B and bit 0 sets C lower. A 1 means input and a 0 means output. After the edge, every output-enable bit of an output group is 1 and every output-enable bit of an input group is 0. All 16 combinations are accepted.
- R4: A valid configuration word clears all three latches and both interrupt-enable flops.
- R5: A word with bit 7 = 1 where bit 6, 5 or 2 is 1 is ignored. Directions, latches and enables all stay unchanged.
- R6: A control word with bit 7 = 0 is a bit command. Bits 3..1 give the port C bit number, with bit 1 as the least significant bit. Bit 0 is the new value of that bit. Bits 6..4 are ignored. Only the selected `pcOut` bit can change, and the directions stay as they were.
- R7: A bit command updates a port C latch bit even when its nibble is an input.
- R8: Port C bit 4 controls `intEnable[0]` (group A) and bit 2 controls `intEnable[1]` (group B). A bit command on one of these bits sets or clears that flop and leaves the other flop unchanged.
- R9: While `cs` and `rd` are high, a read of port A or port B returns the pins if the port is an input and the latch if it is an output. A read of port C builds each nibble the same way, following that nibble's own direction.
- R10: A read of the control address (3) returns 0. `rdData` is 0 whenever `cs` and `rd` are not both high.
- R11: A write while `cs` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe, acted on at the clock edge |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational) |
| paIn | input | 8 | Port A pin inputs |
| paOut | output | 8 | Port A output latch |
| paOe | output | 8 | Port A output enables |
| pbIn | input | 8 | Port B pin inputs |
| pbOut | output | 8 | Port B output latch |
| pbOe | output | 8 | Port B output enables |
| pcIn | input | 8 | Port C pin inputs |
| pcOut | output | 8 | Port C output latch |
| pcOe | output | 8 | Port C output enables, per nibble |
| intEnable | output | 2 | Interrupt-enable flops: [0] group A, [1] group B |

## Verification
The bench builds the block with its default parameters: an 8-bit port width, which gives a 3-bit bit-number field, and the enable flops placed on port C bits 4 and 2. These values make every one of the 16 direction combinations, all eight bit-command targets, and the two enable bits with their neighbours reachable through the real control word layout. Because the two enable bits sit in different nibbles, a single mixed-direction configuration shows that the enable flops do not depend on nibble direction.

// File: rtl/pio_pkg.sv
package pio_pkg;

  // Strobes passed from the bus decoder to the datapath, valid for one cycle
  typedef struct packed {
    logic       ldA;
    logic       ldB;
    logic       ldC;
    logic       bitOp;
    logic [2:0] bitIdx;
    logic       bitVal;
    logic       modeLd;
  } pioStrobe_t;

  // Direction of the four groups, 1 = input
  typedef struct packed {
    logic aIn;
    logic cuIn;
    logic bIn;
    logic clIn;
  } pioDir_t;

  localparam logic [1:0] ADDR_A    = 2'd0;
  localparam logic [1:0] ADDR_B    = 2'd1;
  localparam logic [1:0] ADDR_C    = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output pioStrobe_t        stb,
  output pioDir_t           dir
);

  logic ctrlWrite;
  logic modeShape;

  assign ctrlWrite = cs && wr && (addr == ADDR_CTRL);
  // bits 6, 5 and 2 must all be zero for a basic-mode configuration
  assign modeShape = (wrData[6:5] == 2'b00) && !wrData[2];

  always_comb begin
    stb = '0;
    if (cs && wr) begin
      unique case (addr)
        ADDR_A: stb.ldA = 1'b1;
        ADDR_B: stb.ldB = 1'b1;
        ADDR_C: stb.ldC = 1'b1;
        default: begin
          if (wrData[7]) begin
            stb.modeLd = modeShape;
          end else begin
            stb.bitOp  = 1'b1;
            stb.bitIdx = wrData[3:1];
            stb.bitVal = wrData[0];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dir <= '1;
    end else if (ctrlWrite && stb.modeLd) begin
      dir.aIn  <= wrData[4];
      dir.cuIn <= wrData[3];
      dir.bIn  <= wrData[1];
      dir.clIn <= wrData[0];
    end
  end

endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int INTE_A_BIT = 4,
  parameter int INTE_B_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pioStrobe_t        stb,
  input  pioDir_t           dir,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] paIn,
  input  logic [DATA_W-1:0] pbIn,
  input  logic [DATA_W-1:0] pcIn,
  output logic [DATA_W-1:0] latA,
  output logic [DATA_W-1:0] latB,
  output logic [DATA_W-1:0] latC,
  output logic [DATA_W-1:0] paOe,
  output logic [DATA_W-1:0] pbOe,
  output logic [DATA_W-1:0] pcOe,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        intEnable
);

  localparam int HALF  = DATA_W / 2;
  localparam int IDX_W = $clog2(DATA_W);
  localparam int NUM_INTE = 2;
  localparam int IntePos [NUM_INTE] = '{INTE_A_BIT, INTE_B_BIT};

  always_ff @(posedge clk) begin
    if (!rstN || stb.modeLd) begin
      latA <= '0;
      latB <= '0;
    end else begin
      if (stb.ldA) latA <= wrData;
      if (stb.ldB) latB <= wrData;
    end
  end

  // Each port C bit owns its update path so a bit command touches only one flop
  for (genvar i = 0; i < DATA_W; i++) begin : g_portC
    always_ff @(posedge clk) begin
      if (!rstN || stb.modeLd) begin
        latC[i] <= 1'b0;
      end else if (stb.ldC) begin
        latC[i] <= wrData[i];
      end else if (stb.bitOp && (stb.bitIdx == IDX_W'(i))) begin
        latC[i] <= stb.bitVal;
      end
    end
  end

  for (genvar g = 0; g < NUM_INTE; g++) begin : g_inte
    always_ff @(posedge clk) begin
      if (!rstN || stb.modeLd) begin
        intEnable[g] <= 1'b0;
      end else if (stb.bitOp && (stb.bitIdx == IDX_W'(IntePos[g]))) begin
        intEnable[g] <= stb.bitVal;
      end
    end
  end

  assign paOe = {DATA_W{~dir.aIn}};
  assign pbOe = {DATA_W{~dir.bIn}};
  assign pcOe = {{HALF{~dir.cuIn}}, {HALF{~dir.clIn}}};

  logic [HALF-1:0] rdCUpper;
  logic [HALF-1:0] rdCLower;

  assign rdCUpper = dir.cuIn ? pcIn[DATA_W-1:HALF] : latC[DATA_W-1:HALF];
  assign rdCLower = dir.clIn ? pcIn[HALF-1:0]      : latC[HALF-1:0];

  always_comb begin
    rdData = '0;
    if (rdSel) begin
      unique case (addr)
        ADDR_A:  rdData = dir.aIn ? paIn : latA;
        ADDR_B:  rdData = dir.bIn ? pbIn : latB;
        ADDR_C:  rdData = {rdCUpper, rdCLower};
        default: rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
  import pio_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int INTE_A_BIT = 4,
  parameter int INTE_B_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic [1:0]        addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] paIn,
  output logic [DATA_W-1:0] paOut,
  output logic [DATA_W-1:0] paOe,
  input  logic [DATA_W-1:0] pbIn,
  output logic [DATA_W-1:0] pbOut,
  output logic [DATA_W-1:0] pbOe,
  input  logic [DATA_W-1:0] pcIn,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] pcOe,
  output logic [1:0]        intEnable
);

  pioStrobe_t stb;
  pioDir_t    dir;

  pio_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cs     (cs),
    .wr     (wr),
    .addr   (addr),
    .wrData (wrData),
    .stb    (stb),
    .dir    (dir)
  );

  pio_datapath #(
    .DATA_W     (DATA_W),
    .INTE_A_BIT (INTE_A_BIT),
    .INTE_B_BIT (INTE_B_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .dir       (dir),
    .wrData    (wrData),
    .rdSel     (cs && rd),
    .addr      (addr),
    .paIn      (paIn),
    .pbIn      (pbIn),
    .pcIn      (pcIn),
    .latA      (paOut),
    .latB      (pbOut),
    .latC      (pcOut),
    .paOe      (paOe),
    .pbOe      (pbOe),
    .pcOe      (pcOe),
    .rdData    (rdData),
    .intEnable (intEnable)
  );

endmodule

// File: rtl/pio_port_ctrl_checker.sv
module pio_port_ctrl_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cs,
  input logic [1:0]        addr,
  input logic              rd,
  input logic              wr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] paOut,
  input logic [DATA_W-1:0] paOe,
  input logic [DATA_W-1:0] pbOut,
  input logic [DATA_W-1:0] pbOe,
  input logic [DATA_W-1:0] pcOut,
  input logic [DATA_W-1:0] pcOe,
  input logic [1:0]        intEnable
);

  localparam int HALF = DATA_W / 2;

  logic ctrlWr, goodMode, badMode, bitCmd;
  assign ctrlWr   = cs && wr && (addr == 2'd3);
  assign goodMode = ctrlWr && wrData[7] && (wrData[6:5] == 2'b00) && !wrData[2];
  assign badMode  = ctrlWr && wrData[7] && !((wrData[6:5] == 2'b00) && !wrData[2]);
  assign bitCmd   = ctrlWr && !wrData[7];

  p_mode_dir_r3: assert property (@(posedge clk) disable iff (!rstN)
    goodMode |=> (paOe == {DATA_W{~$past(wrData[4])}}) &&
                 (pbOe == {DATA_W{~$past(wrData[1])}}) &&
                 (pcOe == {{HALF{~$past(wrData[3])}}, {HALF{~$past(wrData[0])}}}));

  p_mode_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    goodMode |=> (paOut == '0) && (pbOut == '0) && (pcOut == '0) && (intEnable == 2'b00));

  p_bad_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    badMode |=> $stable(paOe) && $stable(pbOe) && $stable(pcOe) &&
                $stable(paOut) && $stable(pbOut) && $stable(pcOut) && $stable(intEnable));

  p_bit_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    bitCmd |=> (pcOut[$past(wrData[3:1])] == $past(wrData[0])) &&
               ($countones(pcOut ^ $past(pcOut)) <= 1) && $stable(pcOe));

  p_ctrl_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!(cs && rd) || (addr == 2'd3)) |-> (rdData == '0));

  p_no_cs_r11: assert property (@(posedge clk) disable iff (!rstN)
    !cs |=> $stable(paOut) && $stable(pbOut) && $stable(pcOut) &&
            $stable(paOe) && $stable(intEnable));

endmodule

bind pio_port_ctrl pio_port_ctrl_checker chk (.*);

// File: tb/pio_port_ctrl_test.sv
`timescale 1ns/1ps
module pio_port_ctrl_test;

  localparam real PERIOD = 8.0;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [7:0] paIn = 8'h00, pbIn = 8'h00, pcIn = 8'h00;
  logic [7:0] paOut, paOe, pbOut, pbOe, pcOut, pcOe;
  logic [1:0] intEnable;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic mA_in = 1, mCu_in = 1, mB_in = 1, mCl_in = 1;
  logic [7:0] mA = 0, mB = 0, mC = 0;
  logic [1:0] mInte = 0;

  always #(PERIOD/2) clk = ~clk;

  pio_port_ctrl uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: mA = d;
      2'd1: mB = d;
      2'd2: mC = d;
      default: begin
        if (d[7]) begin
          if (d[6:5] == 0 && !d[2]) begin
            mA_in = d[4]; mCu_in = d[3]; mB_in = d[1]; mCl_in = d[0];
            mA = 0; mB = 0; mC = 0; mInte = 0;
          end
        end else begin
          mC[d[3:1]] = d[0];
          if (d[3:1] == 3'd4) mInte[0] = d[0];
          if (d[3:1] == 3'd2) mInte[1] = d[0];
        end
      end
    endcase
  endtask

  function automatic logic [7:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0: return mA_in ? paIn : mA;
      2'd1: return mB_in ? pbIn : mB;
      2'd2: return {mCu_in ? pcIn[7:4] : mC[7:4], mCl_in ? pcIn[3:0] : mC[3:0]};
      default: return 8'h00;
    endcase
  endfunction

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R2 model paOut", paOut, mA);
      check("R2 model pbOut", pbOut, mB);
      check("R6 model pcOut", pcOut, mC);
      check("R3 model paOe", paOe, {8{~mA_in}});
      check("R3 model pbOe", pbOe, {8{~mB_in}});
      check("R3 model pcOe", pcOe, {{4{~mCu_in}}, {4{~mCl_in}}});
      check("R8 model intEnable", intEnable, mInte);
      check("R10 idle rdData", rdData, (cs && rd) ? modelRead(addr) : 8'h00);
    end
  end

  task automatic doWrite(input logic [1:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    cs = sel; wr = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    #1;
    if (sel) modelWrite(a, d);
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic doRead(input string tag, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1;
    check(tag, rdData, exp);
    @(posedge clk);
    #1;
    cs = 1'b0; rd = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    paIn = 8'h3C; pbIn = 8'hE1; pcIn = 8'h7B;

    // R1 reset state
    @(negedge clk);
    check("R1 paOe", paOe, 8'h00);
    check("R1 pcOe", pcOe, 8'h00);
    check("R1 latches", {paOut, pbOut, pcOut}, 24'h0);
    check("R1 intEnable", intEnable, 2'b00);
    doRead("R1 read A pins", 2'd0, 8'h3C);

    // R3 every direction combination
    for (int m = 0; m < 16; m++) begin
      logic [7:0] w;
      w = {1'b1, 2'b00, m[3], m[2], 1'b0, m[1], m[0]};
      doWrite(2'd3, w, 1'b1);
      check("R3 paOe", paOe, {8{~m[3]}});
      check("R3 pcOe", pcOe, {{4{~m[2]}}, {4{~m[0]}}});
      check("R3 pbOe", pbOe, {8{~m[1]}});
    end

    // all outputs, R2 data writes
    doWrite(2'd3, 8'h80, 1'b1);
    doWrite(2'd0, 8'h5A, 1'b1);
    doWrite(2'd1, 8'hC3, 1'b1);
    doWrite(2'd2, 8'h96, 1'b1);
    check("R2 paOut", paOut, 8'h5A);
    check("R2 pbOut", pbOut, 8'hC3);
    check("R2 pcOut", pcOut, 8'h96);
    doRead("R9 read A latch", 2'd0, 8'h5A);
    doRead("R9 read C latch", 2'd2, 8'h96);

    // R6 bit commands, junk in bits 6..4
    doWrite(2'd3, 8'h70 | 8'h01, 1'b1);          // bit 0 set
    check("R6 set bit0", pcOut, 8'h97);
    doWrite(2'd3, 8'h50 | (3'd7 << 1), 1'b1);    // bit 7 clear
    check("R6 clear bit7", pcOut, 8'h17);
    check("R6 dirs kept", pcOe, 8'hFF);

    // R8 enables
    doWrite(2'd3, (3'd4 << 1) | 8'h01, 1'b1);
    check("R8 set A enable", intEnable, 2'b01);
    doWrite(2'd3, (3'd2 << 1) | 8'h01, 1'b1);
    check("R8 set B enable", intEnable, 2'b11);
    doWrite(2'd3, (3'd4 << 1), 1'b1);
    check("R8 clear A keeps B", intEnable, 2'b10);
    check("R8 pcOut follows", pcOut, 8'h07);

    // R5 malformed configuration words
    doWrite(2'd3, 8'hA0, 1'b1);
    doWrite(2'd3, 8'hC0, 1'b1);
    doWrite(2'd3, 8'h9F, 1'b1);
    check("R5 latch kept", pcOut, 8'h07);
    check("R5 enable kept", intEnable, 2'b10);
    check("R5 dir kept", paOe, 8'hFF);

    // R11 write without chip select
    doWrite(2'd0, 8'hFF, 1'b0);
    doWrite(2'd3, 8'h9B, 1'b0);
    check("R11 paOut", paOut, 8'h5A);
    check("R11 paOe", paOe, 8'hFF);

    // R4 valid configuration clears everything
    doWrite(2'd3, 8'h89, 1'b1);
    check("R4 latches", {paOut, pbOut, pcOut}, 24'h0);
    check("R4 enables", intEnable, 2'b00);

    // R7 bit command on input nibbles
    doWrite(2'd3, (3'd6 << 1) | 8'h01, 1'b1);
    check("R7 pcOut bit6", pcOut, 8'h40);
    check("R7 pcOe off", pcOe, 8'h00);
    doRead("R9 read C pins", 2'd2, 8'h7B);

    // R9 mixed directions
    doWrite(2'd3, 8'h92, 1'b1);                 // A, B inputs; C outputs
    doWrite(2'd0, 8'h11, 1'b1);
    doWrite(2'd2, 8'hA5, 1'b1);
    paIn = 8'hD2; pbIn = 8'h4E;
    doRead("R9 read A pins", 2'd0, 8'hD2);
    doRead("R9 read B pins", 2'd1, 8'h4E);
    check("R2 A latch while input", paOut, 8'h11);
    doWrite(2'd3, 8'h88, 1'b1);                 // C upper in, C lower out
    doWrite(2'd2, 8'h3C, 1'b1);
    pcIn = 8'hE7;
    doRead("R9 read C mixed", 2'd2, 8'hEC);
    doRead("R9 read B latch", 2'd1, 8'h00);

    // R10 control read
    doRead("R10 control read", 2'd3, 8'h00);

    repeat (3) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule